// File: doc/BRIEF.md
# Serial Port Word Buffer with Core Access

This block sits between a processor's core-side bus and a bit-serial port that moves one word at a time. A single direction input selects whether the port sends or receives. Core writes always target the transmit buffer and core reads always target the receive buffer. Only the buffer that matches the selected direction may be touched. Each direction owns a two-entry word buffer. Its fill state is reported on a 2-bit status output so software can poll before an access.

The core bus uses a valid/ready handshake, and no access ever returns an error. A read of an empty receive buffer, or a write to a full transmit buffer, waits with ready low until the buffer changes. An access to the buffer of the unused direction while the port is enabled locks the bus permanently. The lock ends only with a synchronous reset.

Level interrupts ask for transmit data or announce a received word, and only while the port is enabled with DMA off. A packed mode carries two 16-bit serial words in each 32-bit buffer word, with the low half first.

Top module: `serial_word_buffer`

## Requirements
- R1: A core write (busWrite=1) that completes with busValid and busReady both high at a clock edge stores busWdata in the transmit buffer. A core read (busWrite=0) returns the oldest receive word on busRdata in the cycle it completes, and that word leaves the buffer at the same edge.
- R2: While the transmit direction is selected and the transmit buffer holds two words, busReady stays low for a write. It rises in the cycle after the serial side takes a word.
- R3: While the receive direction is selected and the receive buffer is empty, busReady stays low for a read. It rises in the cycle after a complete word arrives.
- R4: With cfgEnable high, a core access whose direction differs from cfgTxDir (a read when cfgTxDir=1, a write when cfgTxDir=0) holds busReady low. From then on every access stalls until reset, including accesses to the active buffer.
- R5: rxState and txState encode their buffer as 2'b00 when empty, 2'b10 when holding one word and 2'b11 when holding two words.
- R6: rxIrq is high exactly when cfgEnable=1, cfgDmaEn=0, cfgTxDir=0 and the receive buffer holds at least one word.
- R7: txIrq is high exactly when cfgEnable=1, cfgDmaEn=0, cfgTxDir=1 and the transmit buffer is not full.
- R8: The receiver samples serIn on each serStrobe cycle, most significant bit first. With cfgPack=0, 32 bits form one word. With cfgPack=1, the first 16-bit word becomes bits 15:0 and the second becomes bits 31:16 of one buffer word.
- R9: A serStrobe cycle with no bits pending (or on the last pending bit) loads the oldest transmit word into the shifter. serOut then presents its bits most significant first, one per later serStrobe. With cfgPack=1, bits 15:0 go out first, MSB first, then bits 31:16. serOut is 0 when no bits are pending.
- R10: A received word that completes while the receive buffer is full is discarded, and the buffered words are unchanged.
- R11: A one-cycle synchronous rst empties both buffers, clears the shifters and releases a lock, so a still-held valid access sees busReady in the cycle after reset.
- R12: The receiver ignores serIn and serStrobe unless cfgEnable=1 and cfgTxDir=0. The transmitter shifts only when cfgEnable=1 and cfgTxDir=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous port reset, active high |
| cfgEnable | input | 1 | Port enable |
| cfgTxDir | input | 1 | Direction: 1 transmit, 0 receive |
| cfgDmaEn | input | 1 | DMA enable; masks both interrupts |
| cfgPack | input | 1 | Two 16-bit serial words per buffer word |
| busValid | input | 1 | Core access request |
| busWrite | input | 1 | 1 write (transmit buffer), 0 read (receive buffer) |
| busWdata | input | 32 | Core write data |
| busReady | output | 1 | Access completes at the edge when high with busValid |
| busRdata | output | 32 | Oldest receive word |
| serStrobe | input | 1 | Serial bit enable |
| serIn | input | 1 | Serial receive data |
| serOut | output | 1 | Serial transmit data |
| rxState | output | 2 | Receive buffer status |
| txState | output | 2 | Transmit buffer status |
| rxIrq | output | 1 | Receive word available |
| txIrq | output | 1 | Transmit space available |

## Verification
The bench sweeps both packing modes over patterns that make half swaps and bit-order reversals visible. A packer that swapped halves, or a shifter that sent LSB first, would produce mirrored words on busRdata or serOut. It drives a receive buffer past two words to catch a design that overwrites stored data instead of dropping the new word. It holds accesses against full and empty buffers to catch a ready that leaks through early. It accesses the wrong direction and then the right one, which a design that stalls only the offending access rather than latching a lock would let complete. It also resets with a valid write still held, to expose a lock that outlives the reset edge.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef struct packed {
    logic txPush;
    logic rxPop;
  } swb_strobe_t;

  typedef struct packed {
    logic txFull;
    logic txEmpty;
    logic rxFull;
    logic rxEmpty;
  } swb_level_t;

  localparam logic [1:0] ST_EMPTY = 2'b00;
  localparam logic [1:0] ST_PART  = 2'b10;
  localparam logic [1:0] ST_FULL  = 2'b11;
endpackage

// File: rtl/swb_fifo.sv
module swb_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= pushData;
        wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      end
      if (pop) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      if (push && !pop) count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst) push |-> (!full || pop));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/swb_data.sv
module swb_data
  import swb_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgEnable,
  input  logic              cfgTxDir,
  input  logic              cfgPack,
  input  swb_strobe_t       stb,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  logic              serStrobe,
  input  logic              serIn,
  output logic              serOut,
  output swb_level_t        level,
  output logic [1:0]        rxState,
  output logic [1:0]        txState
);
  localparam int HALF_W = WORD_W / 2;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] WORD_CNT  = CNT_W'(WORD_W);

  logic rxActive, txActive;
  assign rxActive = cfgEnable && !cfgTxDir;
  assign txActive = cfgEnable && cfgTxDir;

  // receive side: shifter and half-word packer
  logic [WORD_W-1:0] rxShift, rxNext, rxPushData;
  logic [CNT_W-1:0]  rxCnt;
  logic              rxHigh, rxLastBit, rxWordDone, rxPush;
  logic [HALF_W-1:0] lowHalf;

  assign rxNext     = {rxShift[WORD_W-2:0], serIn};
  assign rxLastBit  = cfgPack ? (rxCnt == HALF_LAST) : (rxCnt == WORD_LAST);
  assign rxWordDone = serStrobe && rxActive && rxLastBit && (!cfgPack || rxHigh);
  assign rxPushData = cfgPack ? {rxNext[HALF_W-1:0], lowHalf} : rxNext;
  assign rxPush     = rxWordDone && !level.rxFull;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift <= '0;
      rxCnt   <= '0;
      rxHigh  <= 1'b0;
      lowHalf <= '0;
    end else if (serStrobe && rxActive) begin
      rxShift <= rxNext;
      if (rxLastBit) begin
        rxCnt <= '0;
        if (cfgPack) begin
          rxHigh <= !rxHigh;
          if (!rxHigh) lowHalf <= rxNext[HALF_W-1:0];
        end
      end else begin
        rxCnt <= rxCnt + 1'b1;
      end
    end
  end

  // transmit side: loader and shifter
  logic [WORD_W-1:0] txShift, txHead, txLoad;
  logic [CNT_W-1:0]  txLeft;
  logic              txPop;

  assign txPop  = serStrobe && txActive && (txLeft <= 1) && !level.txEmpty;
  assign txLoad = cfgPack ? {txHead[HALF_W-1:0], txHead[WORD_W-1:HALF_W]} : txHead;
  assign serOut = (txLeft != '0) && txShift[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '0;
      txLeft  <= '0;
    end else if (txPop) begin
      txShift <= txLoad;
      txLeft  <= WORD_CNT;
    end else if (serStrobe && txActive && txLeft != '0) begin
      txShift <= {txShift[WORD_W-2:0], 1'b0};
      txLeft  <= txLeft - 1'b1;
    end
  end

  swb_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) uRxBuf (
    .clk(clk), .rst(rst), .push(rxPush), .pushData(rxPushData),
    .pop(stb.rxPop), .popData(busRdata), .full(level.rxFull), .empty(level.rxEmpty));

  swb_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) uTxBuf (
    .clk(clk), .rst(rst), .push(stb.txPush), .pushData(busWdata),
    .pop(txPop), .popData(txHead), .full(level.txFull), .empty(level.txEmpty));

  assign rxState = level.rxEmpty ? ST_EMPTY : (level.rxFull ? ST_FULL : ST_PART);
  assign txState = level.txEmpty ? ST_EMPTY : (level.txFull ? ST_FULL : ST_PART);

  p_rx_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (rxWordDone && level.rxFull && !stb.rxPop) |=> level.rxFull);
  p_rx_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !rxActive |=> $stable(rxCnt));
  p_tx_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !txActive |=> $stable(txLeft));
  p_state_code_r5: assert property (@(posedge clk) disable iff (rst)
    (rxState != 2'b01) && (txState != 2'b01));
endmodule

// File: rtl/swb_ctrl.sv
module swb_ctrl
  import swb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgEnable,
  input  logic        cfgTxDir,
  input  logic        cfgDmaEn,
  input  logic        busValid,
  input  logic        busWrite,
  input  swb_level_t  level,
  output swb_strobe_t stb,
  output logic        busReady,
  output logic        rxIrq,
  output logic        txIrq
);
  logic locked, wrongDir, bufOk, irqOn;

  assign wrongDir = (busWrite != cfgTxDir);
  assign bufOk    = busWrite ? !level.txFull : !level.rxEmpty;
  assign busReady = !locked && !wrongDir && bufOk;

  assign stb.txPush = busValid && busReady && busWrite;
  assign stb.rxPop  = busValid && busReady && !busWrite;

  always_ff @(posedge clk) begin
    if (rst) locked <= 1'b0;
    else if (busValid && cfgEnable && wrongDir) locked <= 1'b1;
  end

  assign irqOn = cfgEnable && !cfgDmaEn;
  assign txIrq = irqOn && cfgTxDir && !level.txFull;
  assign rxIrq = irqOn && !cfgTxDir && !level.rxEmpty;

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (rst) locked |=> locked);
  p_locked_stall_r4: assert property (@(posedge clk) disable iff (rst) locked |-> !busReady);
  p_reset_unlock_r11: assert property (@(posedge clk) rst |=> !locked);
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (rxIrq || txIrq) |-> (cfgEnable && !cfgDmaEn));
  p_irq_excl_r7: assert property (@(posedge clk) disable iff (rst) $onehot0({rxIrq, txIrq}));
endmodule

// File: rtl/serial_word_buffer.sv
module serial_word_buffer
  import swb_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgEnable,
  input  logic              cfgTxDir,
  input  logic              cfgDmaEn,
  input  logic              cfgPack,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [WORD_W-1:0] busWdata,
  output logic              busReady,
  output logic [WORD_W-1:0] busRdata,
  input  logic              serStrobe,
  input  logic              serIn,
  output logic              serOut,
  output logic [1:0]        rxState,
  output logic [1:0]        txState,
  output logic              rxIrq,
  output logic              txIrq
);
  swb_strobe_t stb;
  swb_level_t  level;

  swb_ctrl uCtrl (
    .clk(clk), .rst(rst), .cfgEnable(cfgEnable), .cfgTxDir(cfgTxDir),
    .cfgDmaEn(cfgDmaEn), .busValid(busValid), .busWrite(busWrite),
    .level(level), .stb(stb), .busReady(busReady), .rxIrq(rxIrq), .txIrq(txIrq));

  swb_data #(.WORD_W(WORD_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rst(rst), .cfgEnable(cfgEnable), .cfgTxDir(cfgTxDir),
    .cfgPack(cfgPack), .stb(stb), .busWdata(busWdata), .busRdata(busRdata),
    .serStrobe(serStrobe), .serIn(serIn), .serOut(serOut), .level(level),
    .rxState(rxState), .txState(txState));
endmodule

// File: tb/sim_serial_word_buffer.sv
module sim_serial_word_buffer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgEnable = 0, cfgTxDir = 0, cfgDmaEn = 0, cfgPack = 0;
  logic busValid = 0, busWrite = 0;
  logic [31:0] busWdata = '0;
  logic busReady;
  logic [31:0] busRdata;
  logic serStrobe = 0, serIn = 0, serOut;
  logic [1:0] rxState, txState;
  logic rxIrq, txIrq;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  serial_word_buffer u0 (
    .clk(clk), .rst(rst), .cfgEnable(cfgEnable), .cfgTxDir(cfgTxDir),
    .cfgDmaEn(cfgDmaEn), .cfgPack(cfgPack), .busValid(busValid), .busWrite(busWrite),
    .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata),
    .serStrobe(serStrobe), .serIn(serIn), .serOut(serOut),
    .rxState(rxState), .txState(txState), .rxIrq(rxIrq), .txIrq(txIrq));

  logic [31:0] pats [4] = '{32'h8000_0001, 32'hA5C3_0F96, 32'h1234_5678, 32'hFFFF_0000};

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // serial bit i of word w, in wire order
  function automatic logic wireBit(logic [31:0] w, logic pk, int i);
    if (!pk) return w[31 - i];
    return (i < 16) ? w[15 - i] : w[31 - (i - 16)];
  endfunction

  task automatic sendRx(logic [31:0] w, logic pk);
    for (int i = 0; i < 32; i++) begin
      serIn = wireBit(w, pk, i);
      serStrobe = 1'b1;
      step();
    end
    serStrobe = 1'b0;
  endtask

  task automatic coreRead(logic [31:0] exp, string req);
    busValid = 1'b1; busWrite = 1'b0;
    #1;
    for (int n = 0; n < 20 && !busReady; n++) step();
    chk(req, busRdata, exp);
    step();
    busValid = 1'b0;
  endtask

  task automatic coreWrite(logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busWdata = d;
    #1;
    for (int n = 0; n < 20 && !busReady; n++) step();
    step();
    busValid = 1'b0;
  endtask

  task automatic checkTxBits(logic [31:0] w, logic pk);
    for (int i = 0; i < 32; i++) begin
      chk("R9 serOut bit", {31'b0, serOut}, {31'b0, wireBit(w, pk, i)});
      serStrobe = 1'b1;
      step();
      serStrobe = 1'b0;
    end
  endtask

  task automatic doReset();
    busValid = 1'b0;
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    rst = 1'b0;
    // R11 reset state
    chk("R11 rxState", {30'b0, rxState}, 32'h0);
    chk("R11 txState", {30'b0, txState}, 32'h0);
    chk("R11 serOut", {31'b0, serOut}, 32'h0);
    chk("R6 rxIrq disabled", {31'b0, rxIrq}, 32'h0);

    // receive direction
    cfgEnable = 1'b1; cfgTxDir = 1'b0;
    #1;
    chk("R6 rxIrq empty", {31'b0, rxIrq}, 32'h0);
    busValid = 1'b1; busWrite = 1'b0;
    step(); step(); step();
    chk("R3 read stall", {31'b0, busReady}, 32'h0);
    sendRx(32'hC001_D00D, 1'b0);
    chk("R3 ready after word", {31'b0, busReady}, 32'h1);
    chk("R8 R1 read data", busRdata, 32'hC001_D00D);
    step();
    busValid = 1'b0;
    chk("R5 rx empty", {30'b0, rxState}, 32'h0);

    // R8 sweep over packing modes and patterns
    for (int pk = 0; pk < 2; pk++) begin
      for (int p = 0; p < 4; p++) begin
        cfgPack = pk[0];
        sendRx(pats[p], pk[0]);
        chk("R5 rx one word", {30'b0, rxState}, 32'h2);
        chk("R6 rxIrq word", {31'b0, rxIrq}, 32'h1);
        coreRead(pats[p], "R8 packed word");
        chk("R6 rxIrq drained", {31'b0, rxIrq}, 32'h0);
      end
    end

    // R10 overflow drop
    cfgPack = 1'b0;
    sendRx(32'h1111_2222, 1'b0);
    sendRx(32'h3333_4444, 1'b0);
    chk("R5 rx full", {30'b0, rxState}, 32'h3);
    sendRx(32'h5555_6666, 1'b0);
    chk("R10 still full", {30'b0, rxState}, 32'h3);
    cfgDmaEn = 1'b1; #1;
    chk("R6 rxIrq dma", {31'b0, rxIrq}, 32'h0);
    cfgDmaEn = 1'b0; #1;
    chk("R6 rxIrq back", {31'b0, rxIrq}, 32'h1);
    coreRead(32'h1111_2222, "R10 first kept");
    coreRead(32'h3333_4444, "R10 second kept");
    chk("R10 dropped", {30'b0, rxState}, 32'h0);

    // R12 disabled receiver ignores serial input
    cfgEnable = 1'b0;
    sendRx(32'hDEAD_BEEF, 1'b0);
    cfgEnable = 1'b1; #1;
    chk("R12 rx ignored", {30'b0, rxState}, 32'h0);
    sendRx(32'h0BAD_F00D, 1'b0);
    coreRead(32'h0BAD_F00D, "R12 rx aligned after disable");

    // transmit direction
    doReset();
    cfgEnable = 1'b1; cfgTxDir = 1'b1; #1;
    chk("R7 txIrq empty", {31'b0, txIrq}, 32'h1);
    cfgDmaEn = 1'b1; #1;
    chk("R7 txIrq dma", {31'b0, txIrq}, 32'h0);
    cfgDmaEn = 1'b0;
    for (int pk = 0; pk < 2; pk++) begin
      for (int p = 0; p < 4; p++) begin
        cfgPack = pk[0];
        coreWrite(pats[p]);
        chk("R5 R1 tx one word", {30'b0, txState}, 32'h2);
        serStrobe = 1'b1; step(); serStrobe = 1'b0;
        chk("R9 tx loaded", {30'b0, txState}, 32'h0);
        checkTxBits(pats[p], pk[0]);
        chk("R9 serOut idle", {31'b0, serOut}, 32'h0);
      end
    end

    // R2 full transmit stall
    cfgPack = 1'b0;
    coreWrite(32'hAAAA_0001);
    coreWrite(32'hBBBB_0002);
    chk("R5 tx full", {30'b0, txState}, 32'h3);
    chk("R7 txIrq full", {31'b0, txIrq}, 32'h0);
    busValid = 1'b1; busWrite = 1'b1; busWdata = 32'hCCCC_0003;
    step(); step(); step();
    chk("R2 write stall", {31'b0, busReady}, 32'h0);
    serStrobe = 1'b1; step(); serStrobe = 1'b0; #1;
    chk("R2 ready after pop", {31'b0, busReady}, 32'h1);
    step();
    busValid = 1'b0;
    chk("R2 tx full again", {30'b0, txState}, 32'h3);
    checkTxBits(32'hAAAA_0001, 1'b0);
    chk("R9 next loaded", {30'b0, txState}, 32'h2);
    checkTxBits(32'hBBBB_0002, 1'b0);

    // R4 lock in receive direction
    doReset();
    cfgEnable = 1'b1; cfgTxDir = 1'b0;
    busValid = 1'b1; busWrite = 1'b1; busWdata = 32'h0;
    step(); step();
    chk("R4 wrong write stall", {31'b0, busReady}, 32'h0);
    busValid = 1'b0;
    step();
    sendRx(32'h7777_8888, 1'b0);
    busValid = 1'b1; busWrite = 1'b0;
    step(); step();
    chk("R4 locked read", {31'b0, busReady}, 32'h0);

    // R4 lock in transmit direction and R11 release
    doReset();
    chk("R11 rx cleared", {30'b0, rxState}, 32'h0);
    cfgTxDir = 1'b1;
    busValid = 1'b1; busWrite = 1'b0;
    step(); step();
    chk("R4 wrong read stall", {31'b0, busReady}, 32'h0);
    busWrite = 1'b1; busWdata = 32'h9999_0000;
    step(); step();
    chk("R4 locked write", {31'b0, busReady}, 32'h0);
    rst = 1'b1; step(); rst = 1'b0; #1;
    chk("R11 unlock", {31'b0, busReady}, 32'h1);
    step();
    busValid = 1'b0;
    chk("R11 R1 write after reset", {30'b0, txState}, 32'h2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule